// File: doc/BRIEF.md
# Selectable Analog/Digital Pixel Output Formatter

This block sits in the pixel clock domain, after the sync timing generator and the line store. Each cycle it takes one 18-bit RGB pixel (6 bits per colour), a horizontal sync, a vertical sync and a data-enable. It formats them for one of two display ports. A build-time parameter picks the port. One choice is a parallel colour port meant for a resistor or video DAC. The other is a 12-bit double-data-rate port for a digital video encoder.

In the digital choice, each colour is widened to 8 bits with zero fill in the low bits, giving a 24-bit word. The word is split into two 12-bit halves. Both halves are registered on the same rising edge and handed to an external DDR output register, which sends one half on the rising edge and the other on the falling edge. The sync and enable signals go through the same single register stage in both choices, so every output lags the inputs by exactly one clock.

Top module: `pixel_out_formatter`

## Requirements
- R1: With OUT_MODE = 0 and data-enable high at an edge, the colour outputs show, one clock later, red = pix_in[17:12], green = pix_in[11:6] and blue = pix_in[5:0].
- R2: With OUT_MODE = 0 and data-enable low at an edge, all three colour outputs are zero one clock later, whatever the pixel value.
- R3: With OUT_MODE = 0, both 12-bit digital halves stay at zero on every cycle.
- R4: With OUT_MODE = 1, the 24-bit word is {red, 2'b00, green, 2'b00, blue, 2'b00}, with red in bits 23:18, green in bits 15:10 and blue in bits 7:2.
- R5: With OUT_MODE = 1, one clock after the pixel is sampled, the rising-edge half carries word bits 11:0 and the falling-edge half carries word bits 23:12. Both halves come from the same sampled pixel.
- R6: With OUT_MODE = 1, data-enable does not blank the digital halves, and the parallel colour outputs stay at zero.
- R7: In both modes, hsync, vsync and data-enable appear on their outputs exactly one clock after they are sampled.
- R8: While the synchronous active-high reset is sampled high, every output is zero on the following cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| pix_in | input | 18 | RGB pixel, red high, blue low |
| hs_in | input | 1 | Horizontal sync in |
| vs_in | input | 1 | Vertical sync in |
| de_in | input | 1 | Data-enable in |
| vga_r | output | 6 | Parallel red |
| vga_g | output | 6 | Parallel green |
| vga_b | output | 6 | Parallel blue |
| dvi_rise | output | 12 | Half sent on the rising edge (word bits 11:0) |
| dvi_fall | output | 12 | Half sent on the falling edge (word bits 23:12) |
| hs_out | output | 1 | Registered horizontal sync |
| vs_out | output | 1 | Registered vertical sync |
| de_out | output | 1 | Registered data-enable |

## Verification
The block holds only one register stage, so any wrong stored value reaches the ports on the very next cycle. There it shows as a colour field in the wrong lane, pad bits that are not zero, a sync that is misaligned with its pixel, or a blank that leaks colour. The reference model predicts every output each cycle from the inputs of the previous cycle. It runs against one instance of each mode, so a fault in either mode, or in the unused port, is caught within one clock of when it appears.

// File: rtl/pixfmt_pkg.sv
package pixfmt_pkg;
  localparam int MODE_PARALLEL = 0;
  localparam int MODE_DDR      = 1;
  localparam int NUM_SYNC      = 3;
endpackage

// File: rtl/pixfmt_sync_delay.sv
module pixfmt_sync_delay #(
  parameter int W = 3
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      q     <= '0;
      armed <= 1'b0;
    end else begin
      q     <= d;
      armed <= 1'b1;
    end
  end

  // Controls leave one clock after capture (R7)
  assert_sync_latency_R7: assert property (@(posedge clk) disable iff (rst)
    armed |-> q == $past(d));
endmodule

// File: rtl/pixfmt_parallel_path.sv
module pixfmt_parallel_path #(
  parameter int CW = 6
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [3*CW-1:0] pix,
  input  logic            de,
  output logic [CW-1:0]   r_o,
  output logic [CW-1:0]   g_o,
  output logic [CW-1:0]   b_o
);
  logic armed;

  always_ff @(posedge clk) begin
    if (rst) begin
      r_o   <= '0;
      g_o   <= '0;
      b_o   <= '0;
      armed <= 1'b0;
    end else begin
      armed <= 1'b1;
      if (de) begin
        r_o <= pix[3*CW-1 -: CW];
        g_o <= pix[2*CW-1 -: CW];
        b_o <= pix[CW-1:0];
      end else begin
        r_o <= '0;
        g_o <= '0;
        b_o <= '0;
      end
    end
  end

  assert_active_pass_R1: assert property (@(posedge clk) disable iff (rst)
    (armed && $past(de)) |-> {r_o, g_o, b_o} == $past(pix));
  assert_blank_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (armed && !$past(de)) |-> (r_o == '0 && g_o == '0 && b_o == '0));
endmodule

// File: rtl/pixfmt_ddr_path.sv
module pixfmt_ddr_path #(
  parameter int CW = 6,
  parameter int WW = 8
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [3*CW-1:0]     pix,
  output logic [3*WW/2-1:0]   rise_o,
  output logic [3*WW/2-1:0]   fall_o
);
  localparam int PAD    = WW - CW;
  localparam int WORD_W = 3 * WW;
  localparam int HALF_W = WORD_W / 2;

  logic [WORD_W-1:0] word;
  logic              armed;

  always_comb begin
    word = '0;
    for (int c = 0; c < 3; c++) begin
      word[c*WW + PAD +: CW] = pix[c*CW +: CW];
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rise_o <= '0;
      fall_o <= '0;
      armed  <= 1'b0;
    end else begin
      rise_o <= word[HALF_W-1:0];
      fall_o <= word[WORD_W-1:HALF_W];
      armed  <= 1'b1;
    end
  end

  // Red sits at the top of the falling half, blue above the low pad (R4, R5)
  assert_red_lane_R4: assert property (@(posedge clk) disable iff (rst)
    armed |-> fall_o[HALF_W-1 -: CW] == $past(pix[3*CW-1 -: CW]));
  assert_blue_lane_R5: assert property (@(posedge clk) disable iff (rst)
    armed |-> (rise_o[PAD +: CW] == $past(pix[CW-1:0]) && rise_o[PAD-1:0] == '0));
endmodule

// File: rtl/pixel_out_formatter.sv
module pixel_out_formatter #(
  parameter int OUT_MODE = 0,
  parameter int COLOR_W  = 6,
  parameter int WIDE_W   = 8
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic [3*COLOR_W-1:0]   pix_in,
  input  logic                   hs_in,
  input  logic                   vs_in,
  input  logic                   de_in,
  output logic [COLOR_W-1:0]     vga_r,
  output logic [COLOR_W-1:0]     vga_g,
  output logic [COLOR_W-1:0]     vga_b,
  output logic [3*WIDE_W/2-1:0]  dvi_rise,
  output logic [3*WIDE_W/2-1:0]  dvi_fall,
  output logic                   hs_out,
  output logic                   vs_out,
  output logic                   de_out
);
  import pixfmt_pkg::*;

  localparam int HALF_W = 3 * WIDE_W / 2;

  logic [NUM_SYNC-1:0] ctl_q;

  pixfmt_sync_delay #(.W(NUM_SYNC)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({hs_in, vs_in, de_in}),
    .q   (ctl_q)
  );
  assign {hs_out, vs_out, de_out} = ctl_q;

  generate
    if (OUT_MODE == MODE_PARALLEL) begin : g_parallel
      pixfmt_parallel_path #(.CW(COLOR_W)) u_par (
        .clk (clk),
        .rst (rst),
        .pix (pix_in),
        .de  (de_in),
        .r_o (vga_r),
        .g_o (vga_g),
        .b_o (vga_b)
      );
      assign dvi_rise = '0;
      assign dvi_fall = '0;
    end else begin : g_ddr
      pixfmt_ddr_path #(.CW(COLOR_W), .WW(WIDE_W)) u_ddr (
        .clk    (clk),
        .rst    (rst),
        .pix    (pix_in),
        .rise_o (dvi_rise),
        .fall_o (dvi_fall)
      );
      assign vga_r = '0;
      assign vga_g = '0;
      assign vga_b = '0;
    end
  endgenerate

  logic [HALF_W-1:0] unused_ok;
  assign unused_ok = dvi_rise ^ dvi_fall;

  // Blanking follows the registered enable in parallel mode (R2)
  assert_blank_aligned_R2: assert property (@(posedge clk) disable iff (rst)
    (OUT_MODE == MODE_PARALLEL && !de_out) |-> (vga_r == '0 && vga_g == '0 && vga_b == '0));
endmodule

// File: tb/pixel_out_formatter_test.sv
module pixel_out_formatter_test;
  logic        clk = 1'b0;
  logic        rst;
  logic [17:0] pix_in;
  logic        hs_in, vs_in, de_in;

  logic [5:0]  a_r, a_g, a_b, d_r, d_g, d_b;
  logic [11:0] a_rise, a_fall, d_rise, d_fall;
  logic        a_hs, a_vs, a_de, d_hs, d_vs, d_de;

  int compared   = 0;
  int mismatched = 0;
  bit done       = 0;

  always #5 clk = ~clk;

  pixel_out_formatter #(.OUT_MODE(0)) uut (
    .clk(clk), .rst(rst), .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .vga_r(a_r), .vga_g(a_g), .vga_b(a_b), .dvi_rise(a_rise), .dvi_fall(a_fall),
    .hs_out(a_hs), .vs_out(a_vs), .de_out(a_de));

  pixel_out_formatter #(.OUT_MODE(1)) uut_ddr (
    .clk(clk), .rst(rst), .pix_in(pix_in), .hs_in(hs_in), .vs_in(vs_in), .de_in(de_in),
    .vga_r(d_r), .vga_g(d_g), .vga_b(d_b), .dvi_rise(d_rise), .dvi_fall(d_fall),
    .hs_out(d_hs), .vs_out(d_vs), .de_out(d_de));

  task automatic chk(input string req, input int act, input int exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s at %0t: actual %h expected %h", req, $time, act, exp);
    end
  endtask

  // Expected values predicted from the previous cycle's inputs
  int e_r, e_g, e_b, e_rise, e_fall, e_hs, e_vs, e_de, e_word;
  bit e_rst, e_den;

  function automatic void predict();
    int r, g, b;
    r = int'(pix_in[17:12]);
    g = int'(pix_in[11:6]);
    b = int'(pix_in[5:0]);
    e_rst = rst;
    e_den = de_in;
    if (rst) begin
      e_r = 0; e_g = 0; e_b = 0; e_word = 0; e_hs = 0; e_vs = 0; e_de = 0;
    end else begin
      e_r = de_in ? r : 0;
      e_g = de_in ? g : 0;
      e_b = de_in ? b : 0;
      e_word = (r * 262144) + (g * 1024) + (b * 4);
      e_hs = int'(hs_in); e_vs = int'(vs_in); e_de = int'(de_in);
    end
    e_rise = e_word % 4096;
    e_fall = e_word / 4096;
  endfunction

  task automatic compare_all();
    string pr;
    if (e_rst) begin
      chk("R8 reset parallel r", int'(a_r), 0);
      chk("R8 reset parallel g", int'(a_g), 0);
      chk("R8 reset parallel b", int'(a_b), 0);
      chk("R8 reset ddr rise", int'(d_rise), 0);
      chk("R8 reset ddr fall", int'(d_fall), 0);
      chk("R8 reset hs", int'(a_hs) + int'(d_hs), 0);
      chk("R8 reset vs", int'(a_vs) + int'(d_vs), 0);
      chk("R8 reset de", int'(a_de) + int'(d_de), 0);
    end else begin
      pr = e_den ? "R1 parallel colour" : "R2 parallel blank";
      chk({pr, " r"}, int'(a_r), e_r);
      chk({pr, " g"}, int'(a_g), e_g);
      chk({pr, " b"}, int'(a_b), e_b);
      chk("R7 hs mode0", int'(a_hs), e_hs);
      chk("R7 vs mode0", int'(a_vs), e_vs);
      chk("R7 de mode0", int'(a_de), e_de);
      chk("R7 hs mode1", int'(d_hs), e_hs);
      chk("R7 vs mode1", int'(d_vs), e_vs);
      chk("R7 de mode1", int'(d_de), e_de);
      chk(e_den ? "R5 rise half" : "R6 rise half unblanked", int'(d_rise), e_rise);
      chk(e_den ? "R4 fall half" : "R6 fall half unblanked", int'(d_fall), e_fall);
    end
    chk("R3 parallel mode ddr rise zero", int'(a_rise), 0);
    chk("R3 parallel mode ddr fall zero", int'(a_fall), 0);
    chk("R6 ddr mode colours zero", int'(d_r) + int'(d_g) + int'(d_b), 0);
  endtask

  initial begin
    rst = 1'b1; pix_in = '0; hs_in = 0; vs_in = 0; de_in = 0;
    predict();
    for (int i = 0; i < 1200; i++) begin
      @(negedge clk);
      compare_all();
      rst = (i < 4) || (i >= 600 && i < 603);
      if (i < 20) begin
        pix_in = 18'h3FFFF; de_in = i[0]; hs_in = i[1]; vs_in = i[2];
      end else if (i < 40) begin
        pix_in = '0; de_in = 1; hs_in = 0; vs_in = 1;
      end else if (i < 60) begin
        pix_in = 18'(1 << (i - 40)); de_in = 1; hs_in = i[0]; vs_in = ~i[0];
      end else if (i < 80) begin
        pix_in = 18'h2A955; de_in = 0; hs_in = 1; vs_in = 1;
      end else begin
        pix_in = 18'($urandom); de_in = $urandom % 2; hs_in = $urandom % 2; vs_in = $urandom % 2;
      end
      predict();
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #2000000;
    if (!done) begin
      compared++;
      mismatched++;
      $display("FAIL watchdog expired: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule